// File: doc/BRIEF.md
# Secondary Interrupt Aggregator with Direct Routing

This block gathers 32 level-sensitive interrupt lines into one combined request for a primary interrupt controller. Each input's current level is captured into a raw level vector. A per-line enable mask selects which lines contribute to the combined request. Software manages the mask through separate set and clear words, so no read-modify-write is needed.

A second vector, the direct-route enable, lets lines 21 to 30 bypass the aggregation. A line whose route is enabled drives its own matching output towards the primary controller. That output follows the line's level whatever the mask holds. Two further words give software a shortcut to mask bit 0. This is the software-interrupt path: it changes the enable of line 0 and has no pending bit of its own.

The register port is a simple select/write-enable bus with a byte address that is decoded by word. A small access-phase state machine tracks the access of the previous cycle. Its states are `PH_IDLE` (no access), `PH_WRITE` (a write was taken) and `PH_READ` (a read was taken, so read data is presented). Every state can be entered from every other state on each clock. A select with write enable high leads to `PH_WRITE`. A select with write enable low leads to `PH_READ`. No select leads to `PH_IDLE`.

Top module: `irq_aggregator`

## Requirements
- R1: After reset the level, mask and route-enable vectors are zero, `irq_combined` and all of `irq_route` are low, and `rdata` is zero.
- R2: The raw level vector takes `irq_in` on every clock edge. A read of word 1 returns it.
- R3: `irq_combined` is high exactly when (level AND mask) is nonzero. It updates on the edge that captures the input change or the register write.
- R4: A read of word 0 returns level AND mask.
- R5: A write to word 2 ORs `wdata` into the mask. A read of word 2 returns the mask.
- R6: A write to word 3 clears every mask bit whose `wdata` bit is 1.
- R7: A read of word 4 returns level bit 0 in bit 0, with the other bits zero. A write to word 4 with nonzero `wdata` sets mask bit 0. A zero write has no effect.
- R8: A write to word 5 with nonzero `wdata` clears mask bit 0. A zero write has no effect.
- R9: A write to word 8 ORs (`wdata` AND 0x7FE00000) into the route-enable vector, so only bits 21..30 can be set. A read of word 8 returns that vector.
- R10: A write to word 9 clears every route-enable bit whose `wdata` bit is 1.
- R11: Each `irq_route[i]` with i in 21..30 equals level bit i when route-enable bit i is set, and is low otherwise. It updates on the same edge as the level. `irq_route` bits outside 21..30 are always low.
- R12: Writes to any word other than 2, 3, 4, 5, 8 and 9 change no state. Reads of any word other than 0, 1, 2, 4 and 8 return zero.
- R13: Read data appears on `rdata` in the cycle after an access with `sel` high and `wr_en` low. In every other cycle `rdata` is zero. The word index is `addr[ADDR_W-1:2]`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel | input | 1 | Register access select |
| wr_en | input | 1 | High for write, low for read |
| addr | input | 12 | Byte address, decoded by word |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid the cycle after a read |
| irq_in | input | 32 | Level-sensitive interrupt inputs |
| irq_combined | output | 1 | Combined masked request |
| irq_route | output | 32 | Per-line direct-route outputs |

## Verification
A register write or an input change takes effect on the same rising edge that samples it. Read data is registered on the edge that takes the read and returns to zero one edge later. So each result is due exactly one edge after its stimulus.

The bench drives inputs on falling edges and samples at the next falling edge. This places every check half a period after the edge that owns the result. The read-timing test also samples one more falling edge later, to see `rdata` fall back to zero. Write effects are confirmed by a read-back, or by observing `irq_combined` and `irq_route` directly.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_WRITE = 2'd1,
        PH_READ  = 2'd2
    } bus_phase_e;

    typedef enum logic [3:0] {
        RS_STATUS,
        RS_RAW,
        RS_MASK_SET,
        RS_MASK_CLR,
        RS_SW_SET,
        RS_SW_CLR,
        RS_ROUTE_SET,
        RS_ROUTE_CLR,
        RS_NONE
    } reg_sel_e;

    localparam int unsigned WORD_STATUS    = 0;
    localparam int unsigned WORD_RAW       = 1;
    localparam int unsigned WORD_MASK_SET  = 2;
    localparam int unsigned WORD_MASK_CLR  = 3;
    localparam int unsigned WORD_SW_SET    = 4;
    localparam int unsigned WORD_SW_CLR    = 5;
    localparam int unsigned WORD_ROUTE_SET = 8;
    localparam int unsigned WORD_ROUTE_CLR = 9;

    function automatic reg_sel_e decode_word(input int unsigned w);
        reg_sel_e r;
        case (w)
            WORD_STATUS:    r = RS_STATUS;
            WORD_RAW:       r = RS_RAW;
            WORD_MASK_SET:  r = RS_MASK_SET;
            WORD_MASK_CLR:  r = RS_MASK_CLR;
            WORD_SW_SET:    r = RS_SW_SET;
            WORD_SW_CLR:    r = RS_SW_CLR;
            WORD_ROUTE_SET: r = RS_ROUTE_SET;
            WORD_ROUTE_CLR: r = RS_ROUTE_CLR;
            default:        r = RS_NONE;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/irq_agg_bus_fsm.sv
module irq_agg_bus_fsm
    import irq_agg_pkg::*;
#(
    parameter int unsigned ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    output bus_phase_e        phase,
    output reg_sel_e          acc_sel,
    output logic              wr_stb,
    output logic              rd_stb
);
    localparam int unsigned WORD_W = ADDR_W - 2;

    bus_phase_e phase_q;
    bus_phase_e phase_d;
    logic [WORD_W-1:0] word_idx;

    assign word_idx = addr[ADDR_W-1:2];

    always_comb begin
        phase_d = PH_IDLE;
        unique case (phase_q)
            PH_IDLE, PH_WRITE, PH_READ: begin
                if (sel && wr_en)       phase_d = PH_WRITE;
                else if (sel && !wr_en) phase_d = PH_READ;
                else                    phase_d = PH_IDLE;
            end
            default: phase_d = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) phase_q <= PH_IDLE;
        else        phase_q <= phase_d;
    end

    always_comb begin
        wr_stb  = sel && wr_en;
        rd_stb  = sel && !wr_en;
        acc_sel = decode_word(int'(word_idx));
        phase   = phase_q;
    end

endmodule

// File: rtl/irq_agg_regs.sv
module irq_agg_regs
    import irq_agg_pkg::*;
#(
    parameter int unsigned N_IRQ    = 32,
    parameter int unsigned ROUTE_LO = 21,
    parameter int unsigned ROUTE_HI = 30
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_IRQ-1:0] irq_in,
    input  logic             wr_stb,
    input  logic             rd_stb,
    input  reg_sel_e         acc_sel,
    input  logic [N_IRQ-1:0] wdata,
    output logic [N_IRQ-1:0] level_q,
    output logic [N_IRQ-1:0] mask_q,
    output logic [N_IRQ-1:0] route_q,
    output logic [N_IRQ-1:0] level_d,
    output logic [N_IRQ-1:0] mask_d,
    output logic [N_IRQ-1:0] route_d,
    output logic [N_IRQ-1:0] rd_q
);
    logic [N_IRQ-1:0] route_allow;
    logic [N_IRQ-1:0] rd_val;

    for (genvar i = 0; i < N_IRQ; i++) begin : g_allow
        assign route_allow[i] = (i >= ROUTE_LO) && (i <= ROUTE_HI);
    end

    assign level_d = irq_in;

    always_comb begin
        mask_d  = mask_q;
        route_d = route_q;
        if (wr_stb) begin
            unique case (acc_sel)
                RS_MASK_SET:  mask_d  = mask_q | wdata;
                RS_MASK_CLR:  mask_d  = mask_q & ~wdata;
                RS_SW_SET:    if (|wdata) mask_d[0] = 1'b1;
                RS_SW_CLR:    if (|wdata) mask_d[0] = 1'b0;
                RS_ROUTE_SET: route_d = route_q | (wdata & route_allow);
                RS_ROUTE_CLR: route_d = route_q & ~wdata;
                RS_STATUS, RS_RAW, RS_NONE: ;
                default: ;
            endcase
        end
    end

    always_comb begin
        rd_val = '0;
        unique case (acc_sel)
            RS_STATUS:    rd_val = level_q & mask_q;
            RS_RAW:       rd_val = level_q;
            RS_MASK_SET:  rd_val = mask_q;
            RS_SW_SET:    rd_val[0] = level_q[0];
            RS_ROUTE_SET: rd_val = route_q;
            RS_MASK_CLR, RS_SW_CLR, RS_ROUTE_CLR, RS_NONE: rd_val = '0;
            default: rd_val = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            level_q <= '0;
            mask_q  <= '0;
            route_q <= '0;
            rd_q    <= '0;
        end else begin
            level_q <= level_d;
            mask_q  <= mask_d;
            route_q <= route_d;
            if (rd_stb) rd_q <= rd_val;
        end
    end

endmodule

// File: rtl/irq_agg_out.sv
module irq_agg_out #(
    parameter int unsigned N_IRQ    = 32,
    parameter int unsigned ROUTE_LO = 21,
    parameter int unsigned ROUTE_HI = 30
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_IRQ-1:0] level_d,
    input  logic [N_IRQ-1:0] mask_d,
    input  logic [N_IRQ-1:0] route_d,
    output logic             irq_combined,
    output logic [N_IRQ-1:0] irq_route
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) irq_combined <= 1'b0;
        else        irq_combined <= |(level_d & mask_d);
    end

    for (genvar i = 0; i < N_IRQ; i++) begin : g_route
        if ((i >= ROUTE_LO) && (i <= ROUTE_HI)) begin : g_live
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) irq_route[i] <= 1'b0;
                else        irq_route[i] <= level_d[i] & route_d[i];
            end
        end else begin : g_tied
            assign irq_route[i] = 1'b0;
        end
    end

endmodule

// File: rtl/irq_aggregator.sv
module irq_aggregator
    import irq_agg_pkg::*;
#(
    parameter int unsigned ADDR_W   = 12,
    parameter int unsigned N_IRQ    = 32,
    parameter int unsigned ROUTE_LO = 21,
    parameter int unsigned ROUTE_HI = 30
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [N_IRQ-1:0]  wdata,
    output logic [N_IRQ-1:0]  rdata,
    input  logic [N_IRQ-1:0]  irq_in,
    output logic              irq_combined,
    output logic [N_IRQ-1:0]  irq_route
);
    bus_phase_e       phase;
    reg_sel_e         acc_sel;
    logic             wr_stb;
    logic             rd_stb;
    logic [N_IRQ-1:0] level_q, mask_q, route_q;
    logic [N_IRQ-1:0] level_d, mask_d, route_d;
    logic [N_IRQ-1:0] rd_q;

    irq_agg_bus_fsm #(.ADDR_W(ADDR_W)) u_fsm (
        .clk    (clk),
        .rst_n  (rst_n),
        .sel    (sel),
        .wr_en  (wr_en),
        .addr   (addr),
        .phase  (phase),
        .acc_sel(acc_sel),
        .wr_stb (wr_stb),
        .rd_stb (rd_stb)
    );

    irq_agg_regs #(.N_IRQ(N_IRQ), .ROUTE_LO(ROUTE_LO), .ROUTE_HI(ROUTE_HI)) u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .irq_in (irq_in),
        .wr_stb (wr_stb),
        .rd_stb (rd_stb),
        .acc_sel(acc_sel),
        .wdata  (wdata),
        .level_q(level_q),
        .mask_q (mask_q),
        .route_q(route_q),
        .level_d(level_d),
        .mask_d (mask_d),
        .route_d(route_d),
        .rd_q   (rd_q)
    );

    irq_agg_out #(.N_IRQ(N_IRQ), .ROUTE_LO(ROUTE_LO), .ROUTE_HI(ROUTE_HI)) u_out (
        .clk         (clk),
        .rst_n       (rst_n),
        .level_d     (level_d),
        .mask_d      (mask_d),
        .route_d     (route_d),
        .irq_combined(irq_combined),
        .irq_route   (irq_route)
    );

    assign rdata = (phase == PH_READ) ? rd_q : '0;

endmodule

// File: rtl/irq_agg_checker.sv
module irq_agg_checker #(
    parameter int unsigned ADDR_W   = 12,
    parameter int unsigned N_IRQ    = 32,
    parameter int unsigned ROUTE_LO = 21,
    parameter int unsigned ROUTE_HI = 30
) (
    input logic              clk,
    input logic              rst_n,
    input logic              sel,
    input logic              wr_en,
    input logic [ADDR_W-1:0] addr,
    input logic [N_IRQ-1:0]  wdata,
    input logic [N_IRQ-1:0]  rdata,
    input logic              irq_combined,
    input logic [N_IRQ-1:0]  irq_route,
    input logic [N_IRQ-1:0]  level_q,
    input logic [N_IRQ-1:0]  mask_q,
    input logic [N_IRQ-1:0]  route_q
);
    logic [N_IRQ-1:0]  allow;
    logic [ADDR_W-3:0] w;
    logic              wr_any, wr_unmapped;

    for (genvar i = 0; i < N_IRQ; i++) begin : g_al
        assign allow[i] = (i >= ROUTE_LO) && (i <= ROUTE_HI);
    end

    assign w           = addr[ADDR_W-1:2];
    assign wr_any      = sel && wr_en;
    assign wr_unmapped = wr_any && !(w == 2 || w == 3 || w == 4 || w == 5 || w == 8 || w == 9);

    AST_COMBINED_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
        irq_combined == |(level_q & mask_q));  // R3

    AST_ROUTE_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
        irq_route == (level_q & route_q));  // R11

    AST_ROUTE_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_route & ~allow) == '0);  // R11

    AST_ROUTE_EN_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        (route_q & ~allow) == '0);  // R9

    AST_RDATA_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !(sel && !wr_en) |=> (rdata == '0));  // R13

    AST_MASK_SET_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_any && w == 2) |=> ((mask_q & $past(wdata)) == $past(wdata)));  // R5

    AST_UNMAPPED_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_unmapped |=> ($stable(mask_q) && $stable(route_q)));  // R12

endmodule

bind irq_aggregator irq_agg_checker #(
    .ADDR_W(ADDR_W), .N_IRQ(N_IRQ), .ROUTE_LO(ROUTE_LO), .ROUTE_HI(ROUTE_HI)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .sel         (sel),
    .wr_en       (wr_en),
    .addr        (addr),
    .wdata       (wdata),
    .rdata       (rdata),
    .irq_combined(irq_combined),
    .irq_route   (irq_route),
    .level_q     (level_q),
    .mask_q      (mask_q),
    .route_q     (route_q)
);

// File: tb/tb_irq_aggregator.sv
`timescale 1ns/1ps
module tb_irq_aggregator;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sel = 1'b0;
    logic        wr_en = 1'b0;
    logic [11:0] addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [31:0] irq_in = '0;
    logic        irq_combined;
    logic [31:0] irq_route;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    irq_aggregator dut (
        .clk(clk), .rst_n(rst_n), .sel(sel), .wr_en(wr_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .irq_in(irq_in),
        .irq_combined(irq_combined), .irq_route(irq_route)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
        end
    endtask

    task automatic bus_write(input int word, input logic [31:0] d);
        @(negedge clk);
        sel = 1'b1; wr_en = 1'b1; addr = 12'(word * 4); wdata = d;
        @(negedge clk);
        sel = 1'b0; wr_en = 1'b0; wdata = '0;
    endtask

    task automatic bus_read(input int word, output logic [31:0] d);
        @(negedge clk);
        sel = 1'b1; wr_en = 1'b0; addr = 12'(word * 4);
        @(negedge clk);
        d = rdata;
        sel = 1'b0;
    endtask

    task automatic set_inputs(input logic [31:0] v);
        @(negedge clk);
        irq_in = v;
        @(negedge clk);
    endtask

    task automatic t_reset();
        logic [31:0] d;
        chk("R1 combined", {31'b0, irq_combined}, 32'h0);
        chk("R1 route", irq_route, 32'h0);
        chk("R1 rdata", rdata, 32'h0);
        bus_read(1, d); chk("R1 level", d, 32'h0);
        bus_read(2, d); chk("R1 mask", d, 32'h0);
        bus_read(8, d); chk("R1 route enable", d, 32'h0);
    endtask

    task automatic t_raw();
        logic [31:0] d;
        set_inputs(32'hA5A5_0F0F);
        bus_read(1, d); chk("R2 raw level", d, 32'hA5A5_0F0F);
        bus_read(0, d); chk("R4 status unmasked", d, 32'h0);
        chk("R3 combined low with empty mask", {31'b0, irq_combined}, 32'h0);
    endtask

    task automatic t_mask();
        logic [31:0] d;
        bus_write(2, 32'h0000_00F0);
        bus_read(2, d); chk("R5 mask first set", d, 32'h0000_00F0);
        bus_write(2, 32'h0F00_0000);
        bus_read(2, d); chk("R5 mask accumulates", d, 32'h0F00_00F0);
        chk("R3 combined high", {31'b0, irq_combined}, 32'h1);
        bus_read(0, d); chk("R4 status", d, 32'h0500_0000);
        bus_write(3, 32'h0F00_0000);
        bus_read(2, d); chk("R6 mask cleared", d, 32'h0000_00F0);
        chk("R3 combined low after clear", {31'b0, irq_combined}, 32'h0);
    endtask

    task automatic t_soft();
        logic [31:0] d;
        bus_read(4, d); chk("R7 soft read level bit0", d, 32'h1);
        bus_write(4, 32'h0);
        bus_read(2, d); chk("R7 zero write ignored", d, 32'h0000_00F0);
        chk("R7 combined still low", {31'b0, irq_combined}, 32'h0);
        bus_write(4, 32'h100);
        bus_read(2, d); chk("R7 mask bit0 set", d, 32'h0000_00F1);
        chk("R3 combined via bit0", {31'b0, irq_combined}, 32'h1);
        bus_write(5, 32'h0);
        bus_read(2, d); chk("R8 zero write ignored", d, 32'h0000_00F1);
        bus_write(5, 32'h8000_0000);
        bus_read(2, d); chk("R8 mask bit0 cleared", d, 32'h0000_00F0);
        set_inputs(32'h0000_0F0E);
        bus_read(4, d); chk("R7 soft read bit0 low", d, 32'h0);
    endtask

    task automatic t_route();
        logic [31:0] d;
        set_inputs(32'hFFFF_FFFF);
        chk("R11 no route before enable", irq_route, 32'h0);
        bus_write(8, 32'hFFFF_FFFF);
        bus_read(8, d); chk("R9 route enable limited", d, 32'h7FE0_0000);
        chk("R11 routes follow", irq_route, 32'h7FE0_0000);
        bus_write(9, 32'h0030_0000);
        bus_read(8, d); chk("R10 route enable cleared", d, 32'h7FC0_0000);
        chk("R11 cleared route low", irq_route, 32'h7FC0_0000);
        @(negedge clk); irq_in = 32'h4000_0001;
        @(negedge clk);
        chk("R11 route one edge after input", irq_route, 32'h4000_0000);
        bus_write(3, 32'hFFFF_FFFF);
        chk("R11 route independent of mask", irq_route, 32'h4000_0000);
        chk("R3 combined low, mask empty", {31'b0, irq_combined}, 32'h0);
        bus_write(2, 32'h0000_00F0);
    endtask

    task automatic t_unmapped();
        logic [31:0] d;
        bus_write(6, 32'hFFFF_FFFF);
        bus_write(12, 32'hFFFF_FFFF);
        bus_write(1023, 32'hFFFF_FFFF);
        bus_write(0, 32'hFFFF_FFFF);
        bus_read(2, d); chk("R12 mask untouched", d, 32'h0000_00F0);
        bus_read(8, d); chk("R12 route enable untouched", d, 32'h7FC0_0000);
        bus_read(3, d); chk("R12 read word3 zero", d, 32'h0);
        bus_read(6, d); chk("R12 read word6 zero", d, 32'h0);
        bus_read(9, d); chk("R12 read word9 zero", d, 32'h0);
        bus_read(1023, d); chk("R12 read word1023 zero", d, 32'h0);
    endtask

    task automatic t_rd_timing();
        @(negedge clk);
        sel = 1'b1; wr_en = 1'b0; addr = 12'(2 * 4);
        chk("R13 rdata zero before edge", rdata, 32'h0);
        @(negedge clk);
        sel = 1'b0;
        chk("R13 rdata valid next cycle", rdata, 32'h0000_00F0);
        @(negedge clk);
        chk("R13 rdata returns to zero", rdata, 32'h0);
        @(negedge clk);
        sel = 1'b1; wr_en = 1'b1; addr = 12'(2 * 4); wdata = 32'h0;
        @(negedge clk);
        sel = 1'b0; wr_en = 1'b0;
        chk("R13 rdata zero after write", rdata, 32'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_raw();
        t_mask();
        t_soft();
        t_route();
        t_unmapped();
        t_rd_timing();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule